// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K words by 16 bits whose data path is split into a lower byte (bits 7:0) and an upper byte (bits 15:8), each with its own active-low lane enable. The host offers one word access at a time over a request/ready handshake, with an address, write data, a two-bit active-high byte mask and a write flag. The controller turns each request into active-low chip-enable, output-enable, write-enable and lane-enable timing, drives the data bus only while a write is under way, and returns read data with a one-cycle valid strobe.

Every timing figure of the memory is given in nanoseconds as a parameter together with the clock period, and the controller converts each into a whole number of clock cycles: the ceiling of the quotient, never fewer than one. A read holds its strobes for the access time. A write holds write enable low for the longer of the pulse-width and data-setup figures, then releases write enable and its own bus drive together while the address stays put one more cycle. A change of direction between accesses costs one extra idle cycle so the memory and the controller never drive the bus at once. A request with an empty byte mask never touches the memory.

Top module: `sram16_ctrl`

## Requirements
- R1: After reset and whenever `h_ready` is high, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both bits of `mem_lane_n` are 1 and `mem_dq_oe` is 0; `h_ready` is 1 after reset and `h_rvalid` is 0.
- R2: A read with a non-empty mask holds `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 for exactly RD_CYC = max(1, ceil(max(T_AA_NS, T_RC_NS)/CLK_NS)) consecutive cycles, with `mem_lane_n[i]` = NOT `h_be[i]` (bit 0 gates data bits 7:0, bit 1 gates bits 15:8).
- R3: Read data is sampled from `mem_dq_in` on the last read cycle and shown on `h_rdata` with `h_rvalid` high for one cycle right after it; a byte whose mask bit is 0 reads as 8'h00.
- R4: A write with a non-empty mask holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1 with `mem_dq_out` = write data for exactly WE_CYC = max(1, ceil(max(T_PWE_NS, T_SD_NS)/CLK_NS)) cycles; only bytes whose mask bit is 1 change in memory.
- R5: In the cycle where `mem_we_n` returns to 1, `mem_dq_oe` is 0, `mem_ce_n` is 1 and `mem_addr` still holds the write address.
- R6: `mem_dq_oe` is 1 only while `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1, so the controller never drives while the memory may.
- R7: When a non-empty access changes direction from the previous non-empty access, one idle cycle with all strobes high precedes it; `mem_oe_n` never falls in the cycle after `mem_we_n` rises, nor `mem_we_n` in the cycle after `mem_oe_n` rises.
- R8: A request with `h_be`=2'b00 leaves every strobe high and the bus undriven, changes no memory byte, takes one busy cycle, and for a read returns `h_rdata`=16'h0000 with `h_rvalid`.
- R9: A request is taken at a rising edge where `h_req` and `h_ready` are both 1; `h_ready` then stays 0 for RD_CYC cycles (read), WE_CYC+1 cycles (write) or 1 cycle (empty mask), plus 1 when R7 inserts an idle cycle.
- R10: `mem_addr` and `mem_dq_out` stay constant on every cycle of a write after its first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_req | input | 1 | Host request |
| h_ready | output | 1 | Controller idle and able to take a request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Word address |
| h_wdata | input | DATA_W | Write data |
| h_be | input | DATA_W/8 | Active-high byte mask, bit 0 = bits 7:0 |
| h_rvalid | output | 1 | One-cycle read-data strobe |
| h_rdata | output | DATA_W | Read data, disabled bytes zero |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte lane enables, active low, bit 0 = bits 7:0 |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
A wrong state or a stale wait count shows first as strobes of the wrong length: a write-enable or output-enable pulse one cycle short or long appears at the memory pins within the access itself, and the host sees `h_ready` return a cycle early or late on that same access. A lost direction memory shows as a missing or extra idle cycle on the next opposite access, and a wrong lane register shows only when the word is read back, as a byte that changed or a masked byte that did not read as zero.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR,
    ST_WEND,
    ST_SKIP
  } ctl_st_e;

  // Nanoseconds to whole clock cycles, rounded up, at least one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram16_wait_cnt.sv
module sram16_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram16_pin_drive.sv
module sram16_pin_drive
  import sram16_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  ctl_st_e           nxt_st,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [LANES-1:0]  lane_d,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic             ce_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic [LANES-1:0] lane_n_d;

  // Pin levels decoded from the next state, so every strobe leaves a flop.
  always_comb begin
    ce_n_d   = 1'b1;
    oe_n_d   = 1'b1;
    we_n_d   = 1'b1;
    dq_oe_d  = 1'b0;
    lane_n_d = '1;
    case (nxt_st)
      ST_RD: begin
        ce_n_d   = 1'b0;
        oe_n_d   = 1'b0;
        lane_n_d = ~lane_d;
      end
      ST_WR: begin
        ce_n_d   = 1'b0;
        we_n_d   = 1'b0;
        dq_oe_d  = 1'b1;
        lane_n_d = ~lane_d;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_lane_n <= '1;
    end else begin
      mem_ce_n   <= ce_n_d;
      mem_oe_n   <= oe_n_d;
      mem_we_n   <= we_n_d;
      mem_dq_oe  <= dq_oe_d;
      mem_lane_n <= lane_n_d;
    end
  end

  // Address and data change only when a request is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (acc) begin
      mem_addr   <= addr_d;
      mem_dq_out <= wdata_d;
    end
  end

endmodule

// File: rtl/sram16_rd_capture.sv
module sram16_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[g*8 +: 8] <= '0;
      else if (cap_en) rdata[g*8 +: 8] <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= cap_en;
  end

endmodule

// File: rtl/sram16_ctrl.sv
module sram16_ctrl
  import sram16_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_RC_NS  = 10,
  parameter int T_PWE_NS = 7,
  parameter int T_SD_NS  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  h_req,
  output logic                  h_ready,
  input  logic                  h_wr,
  input  logic [ADDR_W-1:0]     h_addr,
  input  logic [DATA_W-1:0]     h_wdata,
  input  logic [DATA_W/8-1:0]   h_be,
  output logic                  h_rvalid,
  output logic [DATA_W-1:0]     h_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = ns_to_cyc(max2(T_AA_NS, T_RC_NS), CLK_NS);
  localparam int WE_CYC = ns_to_cyc(max2(T_PWE_NS, T_SD_NS), CLK_NS);
  localparam int CNT_W  = $clog2(max2(RD_CYC, WE_CYC) + 1);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  ctl_st_e          st_q, st_d;
  logic             acc;
  logic             wr_q;
  logic [LANES-1:0] be_q;
  logic             dir_vld_q, dir_wr_q;
  logic             need_turn;
  logic             cnt_load, cnt_done;
  logic [CNT_W-1:0] cnt_val;
  logic             cap_en;
  logic [LANES-1:0] lane_nxt;

  assign h_ready   = (st_q == ST_IDLE);
  assign acc       = h_ready && h_req;
  assign need_turn = dir_vld_q && (dir_wr_q != h_wr);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (h_req) begin
          if (h_be == '0)     st_d = ST_SKIP;
          else if (need_turn) st_d = ST_TURN;
          else                st_d = h_wr ? ST_WR : ST_RD;
        end
      end
      ST_TURN: st_d = wr_q ? ST_WR : ST_RD;
      ST_RD:   if (cnt_done) st_d = ST_IDLE;
      ST_WR:   if (cnt_done) st_d = ST_WEND;
      ST_WEND: st_d = ST_IDLE;
      ST_SKIP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  // Request fields and the direction of the last real access.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_q <= 1'b0;
      be_q <= '0;
    end else if (acc) begin
      wr_q <= h_wr;
      be_q <= h_be;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dir_vld_q <= 1'b0;
      dir_wr_q  <= 1'b0;
    end else if (acc && (h_be != '0)) begin
      dir_vld_q <= 1'b1;
      dir_wr_q  <= h_wr;
    end
  end

  assign cnt_load = ((st_d == ST_RD) || (st_d == ST_WR)) && (st_d != st_q);
  assign cnt_val  = (st_d == ST_RD) ? CNT_W'(RD_CYC - 1) : CNT_W'(WE_CYC - 1);
  assign cap_en   = ((st_q == ST_RD) && cnt_done) || ((st_q == ST_SKIP) && !wr_q);
  assign lane_nxt = acc ? h_be : be_q;

  sram16_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  sram16_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .acc        (acc),
    .nxt_st     (st_d),
    .addr_d     (h_addr),
    .wdata_d    (h_wdata),
    .lane_d     (lane_nxt),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram16_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cap_en  (cap_en),
    .lane_en (be_q),
    .dq_in   (mem_dq_in),
    .rdata   (h_rdata),
    .rvalid  (h_rvalid)
  );

endmodule

// File: rtl/sram16_ctrl_chk.sv
module sram16_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int RD_CYC = 1,
  parameter int WE_CYC = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                h_ready,
  input logic                h_rvalid,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ce_n,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic [DATA_W/8-1:0] mem_lane_n,
  input logic [DATA_W-1:0]   mem_dq_out,
  input logic                mem_dq_oe
);

  logic [31:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? 32'd0 : we_run + 32'd1;
      oe_run <= mem_oe_n ? 32'd0 : oe_run + 32'd1;
    end
  end

  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_lane_n) && !mem_dq_oe));

  assert_oe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RD_CYC));

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |=> !h_rvalid);

  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WE_CYC));

  assert_write_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && mem_ce_n && !mem_dq_oe));

  assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

  assert_wr_rd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> mem_oe_n);

  assert_rd_wr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> mem_we_n);

  assert_no_empty_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(&mem_lane_n));

  assert_rvalid_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |-> h_ready);

  assert_write_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

bind sram16_ctrl sram16_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .RD_CYC (RD_CYC),
  .WE_CYC (WE_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h_ready    (h_ready),
  .h_rvalid   (h_rvalid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram16_ctrl.sv
module sim_sram16_ctrl;

  // 25 ns access at a 10 ns clock -> 3 read cycles; max(20,5) ns -> 2 write cycles.
  localparam int RD_E = 3;
  localparam int WE_E = 2;

  logic        clk;
  logic        rst_n;
  logic        h_req, h_ready, h_wr, h_rvalid;
  logic [14:0] h_addr;
  logic [15:0] h_wdata, h_rdata;
  logic [1:0]  h_be;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sram16_ctrl #(
    .ADDR_W(15), .DATA_W(16), .CLK_NS(10),
    .T_AA_NS(25), .T_RC_NS(10), .T_PWE_NS(20), .T_SD_NS(5)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_ready(h_ready), .h_wr(h_wr),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_be(h_be), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mdl [int];
  logic [15:0] ref_mem [int];
  bit          mdl_drv;
  bit          pend;
  logic [14:0] p_addr;
  logic [15:0] p_data;
  logic [1:0]  p_lane;

  function automatic logic [15:0] rd_mdl(input logic [14:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : 16'h0000;
  endfunction

  always @* begin
    logic [15:0] v;
    v = rd_mdl(mem_addr);
    mdl_drv = !mem_ce_n && !mem_oe_n && mem_we_n && (mem_lane_n != 2'b11);
    if (mdl_drv)
      mem_dq_in = {mem_lane_n[1] ? 8'hA5 : v[15:8], mem_lane_n[0] ? 8'h5A : v[7:0]};
    else
      mem_dq_in = 16'hFFFF;
  end

  // Commit a write when its low interval ends.
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n && (mem_lane_n != 2'b11)) begin
      pend   <= 1'b1;
      p_addr <= mem_addr;
      p_data <= mem_dq_out;
      p_lane <= mem_lane_n;
    end else if (pend) begin
      logic [15:0] v;
      v = rd_mdl(p_addr);
      if (!p_lane[0]) v[7:0]  = p_data[7:0];
      if (!p_lane[1]) v[15:8] = p_data[15:8];
      mdl[int'(p_addr)] = v;
      pend <= 1'b0;
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q [$];
  int          busy_q [$];
  bit          last_vld = 0;
  bit          last_wr  = 0;

  task automatic access(input bit wr, input logic [14:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    bit          turn;
    logic [15:0] r;
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_req = 1'b1; h_wr = wr; h_addr = a; h_wdata = d; h_be = be;
    turn = (be != 2'b00) && last_vld && (last_wr != wr);
    busy_q.push_back((be == 2'b00) ? 1 : ((wr ? WE_E + 1 : RD_E) + (turn ? 1 : 0)));
    if (be != 2'b00) begin last_vld = 1; last_wr = wr; end
    r = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    if (wr) begin
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      ref_mem[int'(a)] = r;
    end else begin
      exp_q.push_back({be[1] ? r[15:8] : 8'h00, be[0] ? r[7:0] : 8'h00});
    end
    @(negedge clk);
    h_req = 1'b0;
  endtask

  int          busy_cnt = 0;
  int          we_cnt = 0, oe_cnt = 0;
  int          stby_bad = 0, clash = 0;
  bit          prev_we_low = 0;
  logic [14:0] prev_addr;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      // R9 busy length
      if (!h_ready) busy_cnt++;
      else if (busy_cnt > 0) begin
        int e;
        e = (busy_q.size() > 0) ? busy_q.pop_front() : -1;
        chk(busy_cnt == e, "R9/R7 busy cycles", busy_cnt, e);
        busy_cnt = 0;
      end
      // R3 read data
      if (h_rvalid) begin
        logic [15:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
        chk(h_rdata == e, "R3/R8 read data", h_rdata, e);
      end
      // R1 standby and R6 bus contention
      if (h_ready && !(mem_ce_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe))
        stby_bad++;
      if (mem_dq_oe && mdl_drv) clash++;
      // R2 / R4 pulse lengths
      if (!mem_oe_n) oe_cnt++;
      else if (oe_cnt > 0) begin
        chk(oe_cnt == RD_E, "R2 read strobe cycles", oe_cnt, RD_E);
        oe_cnt = 0;
      end
      if (!mem_we_n) begin
        we_cnt++;
        chk(mem_dq_oe && !mem_ce_n && mem_oe_n, "R4 write strobes", {mem_dq_oe, mem_ce_n, mem_oe_n}, 3'b101);
      end else if (we_cnt > 0) begin
        chk(we_cnt == WE_E, "R4 write enable cycles", we_cnt, WE_E);
        we_cnt = 0;
      end
      // R5 release cycle
      if (prev_we_low && mem_we_n)
        chk(!mem_dq_oe && mem_ce_n && (mem_addr == prev_addr), "R5 write release",
            {mem_dq_oe, mem_ce_n, mem_addr}, {2'b01, prev_addr});
      prev_we_low = !mem_we_n;
      prev_addr   = mem_addr;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    h_req = 0; h_wr = 0; h_addr = '0; h_wdata = '0; h_be = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe,
        "R1 pins in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 6'b111110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(h_ready == 1'b1, "R1 ready after reset", h_ready, 1);
    chk(h_rvalid == 1'b0, "R1 rvalid after reset", h_rvalid, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe,
        "R1 standby pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe}, 6'b111110);

    access(1, 15'h0010, 16'h1234, 2'b11);   // R4 full write
    access(1, 15'h7FFF, 16'hBEEF, 2'b11);   // top address
    access(1, 15'h0000, 16'hCAFE, 2'b11);
    access(0, 15'h0010, 16'h0000, 2'b11);   // R7 write->read turn, R2 R3
    access(0, 15'h7FFF, 16'h0000, 2'b01);   // R3 lower only -> 00EF
    access(1, 15'h0010, 16'hAB99, 2'b10);   // R4 upper lane only, R7 turn
    access(0, 15'h0010, 16'h0000, 2'b11);   // expect AB34
    access(1, 15'h0010, 16'hFFFF, 2'b00);   // R8 empty write
    access(0, 15'h0010, 16'h0000, 2'b11);   // still AB34, no turn after empty
    access(0, 15'h0010, 16'h0000, 2'b00);   // R8 empty read -> 0000
    access(0, 15'h0000, 16'h0000, 2'b10);   // upper only -> CA00
    for (int i = 0; i < 6; i++) access(1, 15'(16'h0100 + i), 16'(16'h1111 * (i + 1)), 2'b11);
    for (int i = 0; i < 6; i++) access(0, 15'(16'h0100 + i), 16'h0000, (i % 2 == 0) ? 2'b11 : 2'b01);
    for (int i = 0; i < 4; i++) begin
      access(1, 15'(16'h0200 + i), 16'(16'h0F0F ^ (i * 16'h1357)), 2'b11);
      access(0, 15'(16'h0200 + i), 16'h0000, 2'b11);
    end

    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    chk(busy_q.size() == 0, "R9 all accesses finished", busy_q.size(), 0);
    chk(stby_bad == 0, "R1 standby while ready", stby_bad, 0);
    chk(clash == 0, "R6 no bus contention", clash, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule